// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Target

This block is a synthesizable two-wire (I2C) target holding 256 bytes in a register array. It oversamples SCL and SDA with the system clock, finds START and STOP conditions as SDA transitions while SCL is high, and pulls SDA low through an open-drain enable. A controller can write one byte, write a page of up to 16 bytes, read at the current address, read at a given address, or read a run of bytes back to back.

Written bytes are first collected in a 16-entry page buffer. After the STOP that closes a write, the block runs an internal write cycle of a set number of clock cycles and copies the buffer into the array when that cycle ends. While the cycle runs, the block does not acknowledge its own address, so a controller can poll until the write is done. A write-protect input and a supply-good input both block the copy. Data bytes are still acknowledged when the copy is blocked.

The bus logic needs a system clock at least 16 times the SCL rate, which makes 400 kHz operation possible.

Top module: `i2c_mem_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal binary 1010 followed by `strap_i[2:0]`. Bit 0 selects read (1) or write (0). Any other address byte gets no acknowledge.
- R2: A byte write (address with bit 0 = 0, then a word address, one data byte, then STOP) stores that byte at the word address once the write cycle ends.
- R3: A page write stores each of up to 16 data bytes at consecutive locations, starting at the word address.
- R4: During a page write only the low 4 address bits advance, and they wrap from 15 to 0. Bits 7..4 stay fixed, so no byte lands outside the page.
- R5: A random read returns the byte at the word address loaded just before a repeated START. A current-address read returns the byte one past the location last read.
- R6: A sequential read returns consecutive locations and wraps from address 255 to 0. It ends when the controller answers a byte with no acknowledge, and SDA is then released.
- R7: A STOP that follows at least one data byte starts a write cycle of `WRITE_CYCLES` clocks. During that cycle the target does not acknowledge its address; after it, the target does.
- R8: When `wp_i` is high as the write cycle ends, no memory location changes. Every data byte of the write is still acknowledged.
- R9: When `supply_ok_i` is low as the write cycle ends, no memory location changes. Every data byte of the write is still acknowledged.
- R10: A repeated START restarts address decoding. Data bytes received before it are discarded and start no write cycle.
- R11: After reset, SDA is released, every location reads 0xFF, and the address pointer is 0.
- R12: `sda_pull_o` = 1 pulls SDA low. It changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_i | input | 3 | Address strap bits compared with address bits 3..1 |
| wp_i | input | 1 | Write protect; high blocks the commit to memory |
| supply_ok_i | input | 1 | Supply above the reset threshold; low blocks the commit |

## Verification
Two events can fall in the same clock: the end of the write cycle, which copies the page buffer into the array, and the decision whether to acknowledge a newly received address byte. The bench sends an address poll at once after a write's STOP and expects no acknowledge. It polls again after the window and expects an acknowledge. It then reads the location back, which shows that the copy finished before the first acknowledged access. Assertions check that busy starts only from a STOP after data, that no acknowledge is given while busy, and that the timer counts down cleanly to its final cycle.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int PAGE_W  = 4;
  localparam int STRAP_W = 3;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WORD, ST_WORD_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } xfer_state_e;

  // next address inside a page: low bits wrap, page number held
  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_W], PAGE_W'(a[PAGE_W-1:0] + 1'b1)};
  endfunction

  // next address for reads: whole space wraps
  function automatic logic [ADDR_W-1:0] seq_step(input logic [ADDR_W-1:0] a);
    return ADDR_W'(a + 1'b1);
  endfunction

  function automatic logic dev_match(input logic [DATA_W-1:0] b,
                                     input logic [STRAP_W-1:0] s);
    return b[DATA_W-1:1] == {DEV_TYPE, s};
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_STAGES-1];
      sda_q  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_ff[SYNC_STAGES-1];
  assign sda_o      = sda_ff[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_write_timer.sv
module i2c_write_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (launch_i)     cnt <= CNT_W'(CYCLES);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);
  assign done_o = (cnt == CNT_W'(1));

  p_timer_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CYCLES));
  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o,
  input  logic                     buf_clear_i,
  input  logic                     buf_we_i,
  input  logic [PAGE_W-1:0]        buf_idx_i,
  input  logic [DATA_W-1:0]        buf_data_i,
  input  logic                     commit_i,
  input  logic [ADDR_W-PAGE_W-1:0] page_i
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [DATA_W-1:0]     mem  [DEPTH];
  logic [DATA_W-1:0]     pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (commit_i) begin
      for (int j = 0; j < PAGE_BYTES; j++)
        if (pvalid[j]) mem[{page_i, PAGE_W'(j)}] <= pbuf[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pvalid <= '0;
    else if (buf_clear_i) pvalid <= '0;
    else if (buf_we_i)    pvalid[buf_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (buf_we_i) pbuf[buf_idx_i] <= buf_data_i;
  end

  assign rd_data_o = mem[rd_addr_i];

  // a commit always carries at least one loaded byte
  p_commit_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> (pvalid != '0));
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter int WRITE_CYCLES = 2000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wp_i,
  input  logic               supply_ok_i
);
  localparam int BIT_W = $clog2(DATA_W + 1);

  // named internal events
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic byte_done, addr_hit, buf_we, buf_clear, launch, inhibit, commit;
  logic wt_busy, wt_done;

  xfer_state_e               state;
  logic [BIT_W-1:0]          bitcnt;
  logic [DATA_W-1:0]         shreg, tx, rd_data;
  logic [ADDR_W-1:0]         ptr;
  logic [ADDR_W-PAGE_W-1:0]  page;
  logic                      rd_mode, wr_pending, pull;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev));

  i2c_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .busy_o(wt_busy), .done_o(wt_done));

  i2c_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr_i(ptr), .rd_data_o(rd_data),
    .buf_clear_i(buf_clear), .buf_we_i(buf_we), .buf_idx_i(ptr[PAGE_W-1:0]),
    .buf_data_i(shreg), .commit_i(commit), .page_i(page));

  assign byte_done = scl_fall && (bitcnt == BIT_W'(DATA_W));
  assign addr_hit  = dev_match(shreg, strap_i) && !wt_busy;
  assign buf_we    = byte_done && (state == ST_WDATA);
  assign buf_clear = byte_done && (state == ST_WORD);
  assign launch    = stop_ev && wr_pending;
  assign inhibit   = wp_i || !supply_ok_i;
  assign commit    = wt_done && !inhibit;
  assign sda_pull_o = pull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bitcnt <= '0; shreg <= '0; tx <= '0; ptr <= '0;
      page <= '0; rd_mode <= 1'b0; wr_pending <= 1'b0; pull <= 1'b0;
    end else if (start_ev) begin
      state <= ST_DEV; bitcnt <= '0; pull <= 1'b0; wr_pending <= 1'b0;
    end else if (stop_ev) begin
      state <= ST_IDLE; pull <= 1'b0; wr_pending <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_WORD, ST_WDATA: begin
          if (scl_rise) begin
            shreg  <= {shreg[DATA_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end
          if (byte_done) begin
            if (state == ST_DEV) begin
              if (addr_hit) begin
                pull <= 1'b1; rd_mode <= shreg[0]; state <= ST_DEV_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_WORD) begin
              ptr <= shreg; pull <= 1'b1; state <= ST_WORD_ACK;
            end else begin
              ptr <= page_step(ptr); page <= ptr[ADDR_W-1:PAGE_W];
              wr_pending <= 1'b1; pull <= 1'b1; state <= ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK, ST_WORD_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            pull <= 1'b0; bitcnt <= '0;
            if (state == ST_DEV_ACK && rd_mode) begin
              tx <= rd_data; pull <= ~rd_data[DATA_W-1];
              ptr <= seq_step(ptr); state <= ST_RDATA;
            end else if (state == ST_DEV_ACK) begin
              state <= ST_WORD;
            end else begin
              state <= ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == BIT_W'(DATA_W - 1)) begin
              pull <= 1'b0; state <= ST_RACK;
            end else begin
              pull <= ~tx[DATA_W-2]; tx <= {tx[DATA_W-2:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise && sda_s) begin
            state <= ST_IDLE;
          end else if (scl_fall) begin
            tx <= rd_data; pull <= ~rd_data[DATA_W-1];
            ptr <= seq_step(ptr); bitcnt <= '0; state <= ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !pull);
  p_sda_hold_scl_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(pull));
  p_busy_from_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wt_busy) |-> $past(stop_ev && wr_pending));
  p_no_ack_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state == ST_DEV && wt_busy) |=> (state == ST_IDLE && !pull));
  p_page_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));
endmodule

// File: tb/tb_i2c_mem_target.sv
`timescale 1ns/1ps
module tb_i2c_mem_target;
  localparam int WC = 1200;
  localparam int Q  = 10;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0, sok = 1'b1;
  logic pull, sda_line;
  int checks = 0, errors = 0, viol = 0;
  logic [7:0] model [256];
  logic scl_p = 1'b1, pull_p = 1'b0;

  assign sda_line = sda_m & ~pull;

  i2c_mem_target #(.WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(pull), .strap_i(STRAP), .wp_i(wp), .supply_ok_i(sok));

  always #2.5 clk = ~clk;

  // R12 monitor: pull may only move while SCL is low
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_p && (pull !== pull_p)) viol++;
    scl_p  <= scl_m;
    pull_p <= pull;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q_wait; repeat (Q) @(negedge clk); endtask
  task automatic bus_start;
    sda_m = 1'b1; q_wait; scl_m = 1'b1; q_wait; sda_m = 1'b0; q_wait; scl_m = 1'b0; q_wait;
  endtask
  task automatic bus_stop;
    sda_m = 1'b0; q_wait; scl_m = 1'b1; q_wait; sda_m = 1'b1; q_wait;
  endtask
  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q_wait; scl_m = 1'b1; q_wait; q_wait; scl_m = 1'b0; q_wait;
    end
    sda_m = 1'b1; q_wait; scl_m = 1'b1; q_wait; ack = !sda_line; q_wait; scl_m = 1'b0; q_wait;
  endtask
  task automatic get_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      q_wait; scl_m = 1'b1; q_wait; b = {b[6:0], sda_line}; q_wait; scl_m = 1'b0; q_wait;
    end
    sda_m = nack; q_wait; scl_m = 1'b1; q_wait; q_wait; scl_m = 1'b0; q_wait; sda_m = 1'b1;
  endtask
  task automatic wait_write; repeat (WC + 100) @(negedge clk); endtask

  function automatic logic [7:0] dev(input logic rd);
    return {4'b1010, STRAP, rd};
  endfunction

  // write n bytes at a; acks checked; model follows the page wrap unless inhibited
  task automatic write_seq(input string req, input logic [7:0] a, input int n,
                           input logic [7:0] d [16], input logic inh);
    logic ack;
    bus_start;
    put_byte(dev(1'b0), ack); chk({req, " dev ack"}, ack, 1);
    put_byte(a, ack);         chk({req, " word ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      put_byte(d[i], ack); chk({req, " data ack"}, ack, 1);
      if (!inh) model[{a[7:4], 4'(a[3:0] + i)}] = d[i];
    end
    bus_stop;
  endtask

  task automatic read_check(input string req, input logic [7:0] a, input int n);
    logic ack; logic [7:0] b;
    bus_start; put_byte(dev(1'b0), ack); put_byte(a, ack);
    bus_start; put_byte(dev(1'b1), ack); chk({req, " read ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i == n - 1, b);
      chk(req, b, model[8'(a + i)]);
    end
    bus_stop;
  endtask

  task automatic t_reset;
    chk("R11 sda released", pull, 0);
    read_check("R11", 8'h40, 2);
  endtask

  task automatic t_address;
    logic ack;
    bus_start; put_byte({4'b1010, 3'b010, 1'b0}, ack); chk("R1 strap mismatch", ack, 0); bus_stop;
    bus_start; put_byte({4'b1011, STRAP, 1'b0}, ack); chk("R1 type mismatch", ack, 0); bus_stop;
    bus_start; put_byte(dev(1'b0), ack); chk("R1 match", ack, 1); bus_stop;
  endtask

  task automatic t_byte_write;
    logic ack; logic [7:0] d [16];
    d = '{default: 8'h00}; d[0] = 8'hA5;
    write_seq("R2", 8'h05, 1, d, 1'b0);
    bus_start; put_byte(dev(1'b0), ack); chk("R7 busy nack", ack, 0); bus_stop;
    wait_write;
    bus_start; put_byte(dev(1'b0), ack); chk("R7 ack after cycle", ack, 1); bus_stop;
    read_check("R2", 8'h05, 1);
  endtask

  task automatic t_page;
    logic [7:0] d [16];
    for (int i = 0; i < 16; i++) d[i] = 8'(8'hC0 ^ (i * 7));
    write_seq("R3", 8'h30, 16, d, 1'b0); wait_write;
    read_check("R3", 8'h30, 16);
  endtask

  task automatic t_wrap;
    logic [7:0] d [16];
    d = '{default: 8'h00}; d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h44;
    write_seq("R4", 8'h4E, 4, d, 1'b0); wait_write;
    read_check("R4", 8'h40, 17);
  endtask

  task automatic t_wp;
    logic [7:0] d [16];
    d = '{default: 8'h5A};
    wp = 1'b1; write_seq("R8", 8'h60, 2, d, 1'b1); wait_write; wp = 1'b0;
    read_check("R8", 8'h60, 2);
  endtask

  task automatic t_supply;
    logic [7:0] d [16];
    d = '{default: 8'h3D};
    sok = 1'b0; write_seq("R9", 8'h62, 2, d, 1'b1); wait_write; sok = 1'b1;
    read_check("R9", 8'h62, 2);
  endtask

  task automatic t_seq_wrap;
    logic ack; logic [7:0] b; logic [7:0] d [16];
    d = '{default: 8'h00};
    d[0] = 8'h77; write_seq("R6", 8'hFF, 1, d, 1'b0); wait_write;
    d[0] = 8'h3C; write_seq("R5", 8'h01, 1, d, 1'b0); wait_write;
    read_check("R6 wrap", 8'hFE, 3);
    chk("R6 released after nack", pull, 0);
    bus_start; put_byte(dev(1'b1), ack); chk("R5 current ack", ack, 1);
    get_byte(1'b1, b); chk("R5 current address", b, model[8'h01]); bus_stop;
  endtask

  task automatic t_rstart;
    logic ack; logic [7:0] b;
    bus_start; put_byte(dev(1'b0), ack); put_byte(8'h70, ack); put_byte(8'h99, ack);
    bus_start; put_byte(dev(1'b1), ack); chk("R10 restart ack", ack, 1);
    get_byte(1'b1, b); chk("R10 random read", b, model[8'h70]); bus_stop;
    bus_start; put_byte(dev(1'b0), ack); chk("R10 no write cycle", ack, 1); bus_stop;
    read_check("R10 discarded", 8'h70, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_address;
    t_byte_write;
    t_page;
    t_wrap;
    t_wp;
    t_supply;
    t_seq_wrap;
    t_rstart;
    chk("R12 sda moved while scl high", viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule